// File: doc/BRIEF.md
# Windowed Register Bank ROM Bridge

This block is the I/O register front end of a peripheral that keeps its boot ROM behind a small banked register window. The host sees four 32-bit words (16 bytes). A command written to the top halfword of the window selects which of eight banks the lower bytes show. Bank 0 offers indirect ROM access: software loads a byte address into a latch, then reads or writes single bytes through a data port. Bank 3 holds a 32-bit configuration word. One 8-bit field of that word decides whether the upper half of the 128 KiB ROM can be reached.

Each host access is a request held high until a one-cycle acknowledge. The access is given by a word index, four byte enables and 32-bit data. Register accesses are acknowledged on the cycle after acceptance. A ROM byte access drives the external byte-wide ROM bus with a fixed-length write-enable or output-enable strobe, and is acknowledged when that strobe ends. When the range gate blocks an access, no strobe is issued: the read returns 0xFF and the write is dropped. The other banks have no contents here.

Top module: `rombank_bridge`

## Requirements
- R1: After reset, the selected bank is 0, the ROM address latch and the configuration word are zero, and rom_we, rom_oe and host_ack are low.
- R2: A write to word index 3 with byte enables 4'b1100 is a bank command. Its halfword value is host_wdata[31:16]. If value bits [15:11] equal 5'b00001, the bank becomes value bits [2:0]; any other command code leaves the bank unchanged. The command works in every bank. A read of word index 3 returns the current bank in bits [18:16], with all other bits zero.
- R3: In bank 0, word index 1 (byte offset 0x04) is the 32-bit ROM address latch. Writes update only the enabled byte lanes, and reads return the full value.
- R4: In bank 3, word index 0 is the 32-bit configuration word. Writes are per byte lane and reads return the full value. In bank 0, word index 0 reads as zero.
- R5: In bank 0, a write to word index 2 with byte enables 4'b0001 (byte offset 0x08) writes host_wdata[7:0] to the ROM. rom_we is high for exactly WE_CYCLES consecutive cycles. rom_addr equals latch bits [16:0] and rom_wdata equals the byte, both stable while rom_we is high. host_ack follows on the cycle after the last rom_we cycle.
- R6: A read of that same byte port raises rom_oe for exactly RD_CYCLES cycles and samples rom_rdata in the last of them. The access completes on the cycle after, returning the byte in bits [7:0] with bits [31:8] zero. rom_we and rom_oe are never high together.
- R7: When configuration bits [27:20] are not 0x06 and latch bit 16 is 1, a ROM-port read returns 0x000000FF and a ROM-port write is dropped, with no strobe in either case. Both are acknowledged one cycle after acceptance. With the field at 0x06, the same accesses reach the ROM.
- R8: Only latch bits [16:0] drive rom_addr. Latch bits [31:17] neither change rom_addr nor affect the range gate.
- R9: Reads from banks other than 0 and 3, or from unused word indices, return zero, and writes to them change nothing. An access to word index 2 with byte enables other than 4'b0001 issues no ROM strobe.
- R10: host_ack is a single-cycle pulse per access. A register access is acknowledged on the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_dw | input | 2 | Word index within the 16-byte window |
| host_be | input | 4 | Byte enables, bit n = byte lane n |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle access completion |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_wdata | output | 8 | ROM write data |
| rom_rdata | input | 8 | ROM read data |
| rom_we | output | 1 | ROM write-enable strobe, active high |
| rom_oe | output | 1 | ROM output-enable strobe, active high |

## Verification
The bench builds the block with WE_CYCLES=3 and RD_CYCLES=2. It keeps the defaults of eight banks, a 17-bit ROM address and a 16-bit limited window. Because the two strobe lengths differ from each other and from the defaults, the exact pulse widths and the acknowledge latencies of 4 and 3 cycles can be measured, and a design that mixes up the two counts is caught. The single gated address bit makes both sides of the range gate reachable with a handful of addresses, including addresses whose upper latch bits would alias if they were decoded.

// File: rtl/rbb_pkg.sv
// Package: shared constants and types for the windowed ROM bridge.
// Assumes a 32-bit host data path split into four byte lanes.
package rbb_pkg;
    localparam logic [4:0] BANK_CMD_CODE = 5'b00001;
    localparam logic [7:0] RX_FULL_MODE  = 8'h06;
    localparam logic [1:0] DW_CFG        = 2'd0;
    localparam logic [1:0] DW_ADDR       = 2'd1;
    localparam logic [1:0] DW_DATA       = 2'd2;
    localparam logic [1:0] DW_CMD        = 2'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_READ  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rbb_bank_sel.sv
// Bank selector: holds the current window bank. Changes it only when a
// bank command carries the expected command code. Assumes sel_wr is
// already qualified by the host decode.
module rbb_bank_sel #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [4:0]        sel_code,
    input  logic [BANK_W-1:0] sel_bank,
    output logic [BANK_W-1:0] bank
);
    import rbb_pkg::*;

    // Bank register update on a valid command
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (sel_wr && sel_code == BANK_CMD_CODE)
            bank <= sel_bank;
    end

    AST_BANK_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_wr && sel_code == BANK_CMD_CODE) |=> $stable(bank)); // R2
endmodule

// File: rtl/rbb_regfile.sv
// Register file: the ROM address latch and the configuration word, both
// written per byte lane. Assumes the write strobes are mutually exclusive.
module rbb_regfile #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_wr,
    input  logic               cfg_wr,
    input  logic [LANES-1:0]   be,
    input  logic [8*LANES-1:0] wdata,
    output logic [8*LANES-1:0] addr_q,
    output logic [8*LANES-1:0] cfg_q
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Address latch byte lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[8*i +: 8] <= '0;
            else if (addr_wr && be[i])
                addr_q[8*i +: 8] <= wdata[8*i +: 8];
        end

        // Configuration word byte lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[8*i +: 8] <= '0;
            else if (cfg_wr && be[i])
                cfg_q[8*i +: 8] <= wdata[8*i +: 8];
        end
    end

    AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_wr && cfg_wr)); // R9
endmodule

// File: rtl/rbb_rom_seq.sv
// ROM strobe sequencer: issues one write-enable pulse of WE_CYCLES or one
// output-enable pulse of RD_CYCLES. done is high in the last strobe cycle.
// Assumes start_wr and start_rd are only raised while idle.
module rbb_rom_seq #(
    parameter int WE_CYCLES = 4,
    parameter int RD_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_wr,
    input  logic       start_rd,
    input  logic [7:0] wbyte,
    output logic       rom_we,
    output logic       rom_oe,
    output logic [7:0] rom_wdata,
    output logic       busy,
    output logic       done,
    output logic       rd_done
);
    import rbb_pkg::*;

    localparam int MAXC = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [15:0]   chk_we_len;
    logic [15:0]   chk_oe_len;

    assign busy    = (state != SEQ_IDLE);
    assign done    = busy && (cnt == '0);
    assign rd_done = (state == SEQ_READ) && (cnt == '0);

    // Strobe state machine and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            cnt       <= '0;
            rom_we    <= 1'b0;
            rom_oe    <= 1'b0;
            rom_wdata <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_wr) begin
                        state     <= SEQ_WRITE;
                        cnt       <= CW'(WE_CYCLES - 1);
                        rom_we    <= 1'b1;
                        rom_wdata <= wbyte;
                    end else if (start_rd) begin
                        state  <= SEQ_READ;
                        cnt    <= CW'(RD_CYCLES - 1);
                        rom_oe <= 1'b1;
                    end
                end
                SEQ_WRITE, SEQ_READ: begin
                    if (cnt == '0) begin
                        state  <= SEQ_IDLE;
                        rom_we <= 1'b0;
                        rom_oe <= 1'b0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Checker counters: length of the current strobe run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_we_len <= '0;
            chk_oe_len <= '0;
        end else begin
            chk_we_len <= rom_we ? chk_we_len + 16'd1 : 16'd0;
            chk_oe_len <= rom_oe ? chk_oe_len + 16'd1 : 16'd0;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_we && rom_oe)); // R6
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_we && $past(rom_we)) |-> $stable(rom_wdata)); // R5
    AST_WE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_we) |-> (chk_we_len == 16'(WE_CYCLES))); // R5
    AST_OE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe) |-> (chk_oe_len == 16'(RD_CYCLES))); // R6
endmodule

// File: rtl/rombank_bridge.sv
// Windowed register bank ROM bridge: decodes host accesses to a 16-byte
// window, routes them to the bank selector, the register file or the ROM
// strobe sequencer, and applies the receiver-mode range gate.
// Assumes host_req stays high until host_ack and NUM_BANKS >= 4.
module rombank_bridge #(
    parameter int NUM_BANKS = 8,
    parameter int ROM_AW    = 17,
    parameter int LIMIT_AW  = 16,
    parameter int WE_CYCLES = 4,
    parameter int RD_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [1:0]        host_dw,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ack,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [7:0]        rom_wdata,
    input  logic [7:0]        rom_rdata,
    output logic              rom_we,
    output logic              rom_oe
);
    import rbb_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [BANK_W-1:0] bank;
    logic [31:0]       addr_q;
    logic [31:0]       cfg_q;
    logic              seq_busy, seq_done, seq_rd_done;
    logic              accept, in_b0, in_b3;
    logic              hit_cmd, hit_addr, hit_data, hit_cfg;
    logic              full_mode, beyond, rom_ok;
    logic              start_wr, start_rd, rom_op;
    logic              sel_wr, addr_wr, cfg_wr;
    logic [31:0]       rd_mux;
    logic              ack_q;
    logic [31:0]       rdata_q;

    // Host decode and range gate
    always_comb begin
        accept    = host_req && !seq_busy && !ack_q;
        in_b0     = (bank == BANK_W'(0));
        in_b3     = (bank == BANK_W'(3));
        hit_cmd   = (host_dw == DW_CMD) && (host_be == 4'b1100);
        hit_addr  = in_b0 && (host_dw == DW_ADDR);
        hit_data  = in_b0 && (host_dw == DW_DATA) && (host_be == 4'b0001);
        hit_cfg   = in_b3 && (host_dw == DW_CFG);
        full_mode = (cfg_q[27:20] == RX_FULL_MODE);
        beyond    = |addr_q[ROM_AW-1:LIMIT_AW];
        rom_ok    = full_mode || !beyond;
        start_wr  = accept && host_wr && hit_data && rom_ok;
        start_rd  = accept && !host_wr && hit_data && rom_ok;
        rom_op    = start_wr || start_rd;
        sel_wr    = accept && host_wr && hit_cmd;
        addr_wr   = accept && host_wr && hit_addr;
        cfg_wr    = accept && host_wr && hit_cfg;
    end

    // Read data selection for register-level reads
    always_comb begin
        rd_mux = '0;
        if (host_dw == DW_CMD)
            rd_mux = {{(16 - BANK_W){1'b0}}, bank, 16'h0000};
        else if (hit_addr)
            rd_mux = addr_q;
        else if (hit_cfg)
            rd_mux = cfg_q;
        else if (hit_data)
            rd_mux = 32'h0000_00FF;
    end

    // Acknowledge pulse and read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= (accept && !rom_op) || seq_done;
            if (accept && !host_wr && !rom_op)
                rdata_q <= rd_mux;
            else if (seq_rd_done)
                rdata_q <= {24'h0, rom_rdata};
        end
    end

    assign host_ack   = ack_q;
    assign host_rdata = rdata_q;
    assign rom_addr   = addr_q[ROM_AW-1:0];

    rbb_bank_sel #(.BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_code (host_wdata[31:27]),
        .sel_bank (host_wdata[16 +: BANK_W]),
        .bank     (bank)
    );

    rbb_regfile #(.LANES(4)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (addr_wr),
        .cfg_wr  (cfg_wr),
        .be      (host_be),
        .wdata   (host_wdata),
        .addr_q  (addr_q),
        .cfg_q   (cfg_q)
    );

    rbb_rom_seq #(.WE_CYCLES(WE_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .wbyte     (host_wdata[7:0]),
        .rom_we    (rom_we),
        .rom_oe    (rom_oe),
        .rom_wdata (rom_wdata),
        .busy      (seq_busy),
        .done      (seq_done),
        .rd_done   (seq_rd_done)
    );

    AST_GATE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_we || rom_oe) |-> (full_mode || !beyond)); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rom_we || rom_oe) && $past(rom_we || rom_oe)) |-> $stable(rom_addr)); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R10
    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (!rom_we && !rom_oe)); // R6
endmodule

// File: tb/sim_rombank_bridge.sv
// Directed bench for rombank_bridge: one task per scenario.
module sim_rombank_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int WE_N = 3;
    localparam int RD_N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_dw = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic [16:0] rom_addr;
    logic [7:0]  rom_wdata;
    logic [7:0]  rom_rdata;
    logic        rom_we, rom_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rombank_bridge #(.WE_CYCLES(WE_N), .RD_CYCLES(RD_N)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_dw(host_dw), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .rom_rdata(rom_rdata), .rom_we(rom_we),
        .rom_oe(rom_oe)
    );

    function automatic logic [7:0] romf(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ (a[16] ? 8'hA5 : 8'h00);
    endfunction

    assign rom_rdata = rom_oe ? romf(rom_addr) : 8'h00;

    // ROM bus monitor, sampled at the falling edge
    int          wr_count = 0, rd_count = 0, we_run = 0, oe_run = 0;
    int          last_we_len = 0, last_oe_len = 0;
    logic [16:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [7:0]  last_wr_data = '0;
    logic        bad_hold = 1'b0;
    logic        prev_we = 1'b0, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rom_we) begin
            if (prev_we && (rom_addr != last_wr_addr || rom_wdata != last_wr_data))
                bad_hold = 1'b1;
            last_wr_addr = rom_addr;
            last_wr_data = rom_wdata;
            we_run++;
        end else if (prev_we) begin
            wr_count++;
            last_we_len = we_run;
            we_run = 0;
        end
        if (rom_oe) begin
            last_rd_addr = rom_addr;
            oe_run++;
        end else if (prev_oe) begin
            rd_count++;
            last_oe_len = oe_run;
            oe_run = 0;
        end
        prev_we = rom_we;
        prev_oe = rom_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [1:0] dw, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_dw = dw; host_be = be; host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ack && lat < 100);
        #1;
        rd = host_rdata;
        host_req = 1'b0;
        if (lat >= 100) begin
            errors++;
            $display("FAIL R10 actual=no_ack expected=ack");
        end
    endtask

    task automatic wr32(input logic [1:0] dw, input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] d; int l;
        xfer(1'b1, dw, be, wd, d, l);
    endtask

    task automatic rd32(input logic [1:0] dw, input logic [3:0] be, output logic [31:0] d);
        int l;
        xfer(1'b0, dw, be, 32'h0, d, l);
    endtask

    task automatic sel_bank(input logic [2:0] b);
        wr32(2'd3, 4'b1100, {16'h0800 | {13'h0, b}, 16'h0});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 ack", {31'h0, host_ack}, 32'h0);
        check("R1 strobes", {30'h0, rom_we, rom_oe}, 32'h0);
        rd32(2'd3, 4'b1100, d);  check("R1 bank", d, 32'h0);
        rd32(2'd1, 4'b1111, d);  check("R1 addr latch", d, 32'h0);
        sel_bank(3'd3);
        rd32(2'd0, 4'b1111, d);  check("R1 cfg", d, 32'h0);
        sel_bank(3'd0);
    endtask

    task automatic t_bank;
        logic [31:0] d; int l;
        xfer(1'b1, 2'd3, 4'b1100, 32'h0805_0000, d, l);
        check("R10 reg write latency", l, 1);
        xfer(1'b0, 2'd3, 4'b1100, 32'h0, d, l);
        check("R2 bank 5", d, 32'h0005_0000);
        check("R10 reg read latency", l, 1);
        wr32(2'd3, 4'b1100, 32'h1003_0000);
        rd32(2'd3, 4'b1100, d);  check("R2 bad code ignored", d, 32'h0005_0000);
        sel_bank(3'd7);
        rd32(2'd3, 4'b1100, d);  check("R2 bank 7", d, 32'h0007_0000);
        sel_bank(3'd0);
        rd32(2'd3, 4'b1100, d);  check("R2 back to bank 0", d, 32'h0);
    endtask

    task automatic t_addr;
        logic [31:0] d;
        wr32(2'd1, 4'b1111, 32'h1234_5678);
        rd32(2'd1, 4'b1111, d);  check("R3 full write", d, 32'h1234_5678);
        wr32(2'd1, 4'b0010, 32'hFFFF_ABFF);
        rd32(2'd1, 4'b1111, d);  check("R3 lane write", d, 32'h1234_AB78);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        sel_bank(3'd3);
        wr32(2'd0, 4'b1111, 32'hDEAD_BEEF);
        rd32(2'd0, 4'b1111, d);  check("R4 cfg rw", d, 32'hDEAD_BEEF);
        wr32(2'd0, 4'b1000, 32'h0100_0000);
        rd32(2'd0, 4'b1111, d);  check("R4 cfg lane", d, 32'h01AD_BEEF);
        wr32(2'd0, 4'b1111, 32'h0);
        sel_bank(3'd0);
        rd32(2'd0, 4'b1111, d);  check("R4 bank0 word0 zero", d, 32'h0);
    endtask

    task automatic t_romwr;
        logic [31:0] d; int l; int wc;
        wr32(2'd1, 4'b1111, 32'h0000_1234);
        wc = wr_count;
        xfer(1'b1, 2'd2, 4'b0001, 32'h0000_003C, d, l);
        check("R5 one pulse", wr_count - wc, 1);
        check("R5 pulse length", last_we_len, WE_N);
        check("R5 addr", {15'h0, last_wr_addr}, 32'h1234);
        check("R5 data", {24'h0, last_wr_data}, 32'h3C);
        check("R5 held stable", {31'h0, bad_hold}, 32'h0);
        check("R5 ack latency", l, WE_N + 1);
    endtask

    task automatic t_romrd;
        logic [31:0] d; int l; int rc;
        wr32(2'd1, 4'b1111, 32'h0000_0456);
        rc = rd_count;
        xfer(1'b0, 2'd2, 4'b0001, 32'h0, d, l);
        check("R6 data", d, {24'h0, romf(17'h0456)});
        check("R6 one pulse", rd_count - rc, 1);
        check("R6 pulse length", last_oe_len, RD_N);
        check("R6 ack latency", l, RD_N + 1);
    endtask

    task automatic t_gate;
        logic [31:0] d; int l; int wc, rc;
        sel_bank(3'd3);
        wr32(2'd0, 4'b1111, 32'h0050_0000);
        sel_bank(3'd0);
        wr32(2'd1, 4'b1111, 32'h0001_0010);
        wc = wr_count; rc = rd_count;
        xfer(1'b0, 2'd2, 4'b0001, 32'h0, d, l);
        check("R7 blocked read FF", d, 32'h0000_00FF);
        check("R7 blocked read latency", l, 1);
        xfer(1'b1, 2'd2, 4'b0001, 32'h0000_0077, d, l);
        check("R7 no strobes", (wr_count - wc) + (rd_count - rc), 0);
        check("R7 blocked write latency", l, 1);
        sel_bank(3'd3);
        wr32(2'd0, 4'b1111, 32'h0060_0000);
        sel_bank(3'd0);
        rd32(2'd2, 4'b0001, d);
        check("R7 full mode read", d, {24'h0, romf(17'h1_0010)});
        wc = wr_count;
        wr32(2'd2, 4'b0001, 32'h0000_0099);
        check("R7 full mode write", wr_count - wc, 1);
        check("R7 full mode addr", {15'h0, last_wr_addr}, 32'h1_0010);
    endtask

    task automatic t_alias;
        logic [31:0] d;
        wr32(2'd1, 4'b1111, 32'hABC1_2345);
        rd32(2'd2, 4'b0001, d);
        check("R8 alias read", d, {24'h0, romf(17'h1_2345)});
        check("R8 bus addr", {15'h0, last_rd_addr}, 32'h1_2345);
        sel_bank(3'd3);
        wr32(2'd0, 4'b1111, 32'h0);
        sel_bank(3'd0);
        wr32(2'd1, 4'b1111, 32'hFFFE_0010);
        rd32(2'd2, 4'b0001, d);
        check("R8 high bits ignored by gate", d, {24'h0, romf(17'h0_0010)});
    endtask

    task automatic t_unimpl;
        logic [31:0] d; int wc, rc;
        wr32(2'd1, 4'b1111, 32'h0000_0100);
        sel_bank(3'd5);
        rd32(2'd1, 4'b1111, d);  check("R9 bank5 read", d, 32'h0);
        wr32(2'd1, 4'b1111, 32'hFFFF_FFFF);
        wc = wr_count; rc = rd_count;
        wr32(2'd2, 4'b0001, 32'h0000_0011);
        rd32(2'd2, 4'b0001, d);  check("R9 bank5 data port", d, 32'h0);
        sel_bank(3'd0);
        rd32(2'd1, 4'b1111, d);  check("R9 latch untouched", d, 32'h0000_0100);
        wr32(2'd2, 4'b0011, 32'h0000_2211);
        rd32(2'd2, 4'b1111, d);  check("R9 wide data read", d, 32'h0);
        check("R9 no strobes", (wr_count - wc) + (rd_count - rc), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank();
        t_addr();
        t_cfg();
        t_romwr();
        t_romrd();
        t_gate();
        t_alias();
        t_unimpl();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule